// File: doc/BRIEF.md
# Presettable Cascadable Down Counter

This block is a small synchronous down counter with a decoded zero flag, meant to serve as one stage of a divide-by-N chain. A build parameter chooses between a decimal digit, which wraps from 0 to 9, and a plain 4-bit binary stage, which wraps from 0 to 15. The count can be decremented by two event sources. One is a rising edge on a count-clock line while the inhibit line is low. The other is a falling edge on the inhibit line while the count clock is high, so inhibit can also serve as a falling-edge clock. Both lines are asynchronous to the block. A free-running system clock samples them through synchronisers and detects their edges.

A clear input forces the count to zero and takes precedence over everything else. A load input copies a preset value into the count, and it keeps doing so for as long as it is held. The zero flag is high only when the count is zero and the cascade-feedback input is high. For a single stage, the zero flag is wired back to the load input, so the counter reloads N each time it runs out. For several digits, each stage takes its cascade feedback from the zero flag of the next more significant stage. The zero flags of all stages drive a shared load line, so the chain reloads only when every digit is zero.

Top module: `dcnt_divider`

## Requirements
- R1: While clr_i is high at a system clock edge, the count becomes 0 at that edge. This holds whatever load_i, preset_i and the edge inputs are doing.
- R2: While clr_i is low and load_i is high, each system clock edge loads preset_i into the count. A count-clock edge detected meanwhile is discarded.
- R3: With clr_i and load_i low, a rising cnt_clk_i while inh_i is low decrements the count by one. The new value appears on the third system clock edge after the change on cnt_clk_i, and not before.
- R4: With clr_i and load_i low, a falling inh_i while cnt_clk_i is high decrements the count by one.
- R5: Some events leave the count unchanged: a rising cnt_clk_i while inh_i is high, any falling cnt_clk_i, and any rising inh_i.
- R6: zero_o is registered together with the count. It is 1 exactly when the count is 0 and casc_fb_i was high at the same edge, and 0 otherwise.
- R7: Decrementing from 0 gives 9 when BCD_MODE=1 and gives 15 when BCD_MODE=0.
- R8: With BCD_MODE=1, the preset values 10 to 15 are loaded unchanged and then decrement normally. For example, 12 becomes 11.
- R9: The synchronous system reset rst clears the count and zero_o.
- R10: With zero_o wired to load_i and casc_fb_i high, a preset of N gives exactly one zero_o pulse, one system clock long, every N count events. The count is back at N after each pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high system reset |
| cnt_clk_i | input | 1 | Asynchronous count clock; its rising edge decrements |
| inh_i | input | 1 | Asynchronous inhibit; high blocks the count clock, and its falling edge decrements |
| clr_i | input | 1 | Counter clear, highest priority |
| load_i | input | 1 | Preset load, level active |
| preset_i | input | CNT_W | Value loaded while load_i is high |
| casc_fb_i | input | 1 | Cascade feedback that qualifies the zero flag |
| count_o | output | CNT_W | Current count |
| zero_o | output | 1 | High when the count is zero and cascade feedback is high |

## Verification
A wrong count register shows up on count_o one system clock after the faulty update. A wrong zero qualification shows up on zero_o in the same cycle. A fault in a synchroniser or in edge detection moves the count update away from the third edge after the input change, or drops the update, or adds one. That is visible within a few cycles of every stimulus. A wrong wrap value or a wrong feedback decode breaks the divide-by-N loop. It then shows as a missing or extra zero pulse, or as a count that does not return to the preset after a pulse.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

  // Action chosen for the count register in one system clock cycle,
  // listed from highest to lowest priority.
  typedef enum logic [1:0] {
    ACT_CLEAR = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_DEC   = 2'd2,
    ACT_HOLD  = 2'd3
  } dcnt_act_e;

  // Two-flop minimum for metastability settling.
  localparam int unsigned DCNT_MIN_SYNC = 2;

endpackage

// File: rtl/dcnt_sync.sv
module dcnt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);

  localparam int unsigned N = (STAGES < dcnt_pkg::DCNT_MIN_SYNC) ?
                              dcnt_pkg::DCNT_MIN_SYNC : STAGES;

  logic [N-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[N-2:0], async_i};
    end
  end

  assign sync_o = chain_q[N-1];

endmodule

// File: rtl/dcnt_edge.sv
module dcnt_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic sync_lvl;
  logic prev_q;

  dcnt_sync #(.STAGES(STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (async_i),
    .sync_o  (sync_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= sync_lvl;
    end
  end

  assign level_o = sync_lvl;
  assign rise_o  = sync_lvl & ~prev_q;
  assign fall_o  = ~sync_lvl & prev_q;

endmodule

// File: rtl/dcnt_core.sv
module dcnt_core
  import dcnt_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter bit          BCD_MODE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             casc_fb_i,
  input  logic             clk_lvl_i,
  input  logic             clk_rise_i,
  input  logic             clk_fall_i,
  input  logic             inh_lvl_i,
  input  logic             inh_rise_i,
  input  logic             inh_fall_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o
);

  localparam logic [CNT_W-1:0] WRAP_VAL = BCD_MODE ? CNT_W'(9) : {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             zero_q;
  logic             dec_evt;
  dcnt_act_e        act;

  // A count event: rising count clock with inhibit low, or falling
  // inhibit with the count clock high.
  assign dec_evt = (clk_rise_i & ~inh_lvl_i) | (inh_fall_i & clk_lvl_i);

  always_comb begin
    if (clr_i)        act = ACT_CLEAR;
    else if (load_i)  act = ACT_LOAD;
    else if (dec_evt) act = ACT_DEC;
    else              act = ACT_HOLD;
  end

  always_comb begin
    unique case (act)
      ACT_CLEAR: cnt_nxt = '0;
      ACT_LOAD:  cnt_nxt = preset_i;
      ACT_DEC:   cnt_nxt = (cnt_q == '0) ? WRAP_VAL : cnt_q - ONE;
      default:   cnt_nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      zero_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      zero_q <= (cnt_nxt == '0) && casc_fb_i;
    end
  end

  assign count_o = cnt_q;
  assign zero_o  = zero_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (count_o == '0)); // R1

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && load_i) |=> (count_o == $past(preset_i))); // R2

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !load_i && dec_evt) |=>
      (count_o == (($past(count_o) == '0) ? WRAP_VAL : $past(count_o) - ONE))); // R7

  AST_IGNORED_EDGES: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !load_i && !clk_rise_i && !inh_fall_i && (clk_fall_i || inh_rise_i))
      |=> $stable(count_o)); // R5

  AST_ZERO_QUAL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (zero_o == ((count_o == '0) && $past(casc_fb_i)))); // R6

endmodule

// File: rtl/dcnt_divider.sv
module dcnt_divider #(
  parameter int unsigned CNT_W       = 4,
  parameter bit          BCD_MODE    = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_clk_i,
  input  logic             inh_i,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             casc_fb_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o
);

  logic clk_lvl, clk_rise, clk_fall;
  logic inh_lvl, inh_rise, inh_fall;

  dcnt_edge #(.STAGES(SYNC_STAGES)) u_clk_edge (
    .clk     (clk),
    .rst     (rst),
    .async_i (cnt_clk_i),
    .level_o (clk_lvl),
    .rise_o  (clk_rise),
    .fall_o  (clk_fall)
  );

  dcnt_edge #(.STAGES(SYNC_STAGES)) u_inh_edge (
    .clk     (clk),
    .rst     (rst),
    .async_i (inh_i),
    .level_o (inh_lvl),
    .rise_o  (inh_rise),
    .fall_o  (inh_fall)
  );

  dcnt_core #(.CNT_W(CNT_W), .BCD_MODE(BCD_MODE)) u_core (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (clr_i),
    .load_i     (load_i),
    .preset_i   (preset_i),
    .casc_fb_i  (casc_fb_i),
    .clk_lvl_i  (clk_lvl),
    .clk_rise_i (clk_rise),
    .clk_fall_i (clk_fall),
    .inh_lvl_i  (inh_lvl),
    .inh_rise_i (inh_rise),
    .inh_fall_i (inh_fall),
    .count_o    (count_o),
    .zero_o     (zero_o)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (count_o == '0 && !zero_o)); // R9

endmodule

// File: tb/dcnt_divider_tb.sv
module dcnt_divider_tb;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_clk = 1'b0;
  logic       inh = 1'b0;
  logic       clr = 1'b0;
  logic       load_r = 1'b0;
  logic [3:0] preset = 4'd0;
  logic       cf = 1'b1;
  logic       fb_mode = 1'b0;

  logic [3:0] cnt_bcd, cnt_bin;
  logic       zero_bcd, zero_bin;
  logic       load_bcd, load_bin;

  int n_run = 0;
  int n_fail = 0;
  int zpulses = 0;
  logic zero_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign load_bcd = fb_mode ? zero_bcd : load_r;
  assign load_bin = fb_mode ? zero_bin : load_r;

  dcnt_divider #(.CNT_W(4), .BCD_MODE(1'b1), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .cnt_clk_i(cnt_clk), .inh_i(inh), .clr_i(clr),
    .load_i(load_bcd), .preset_i(preset), .casc_fb_i(cf),
    .count_o(cnt_bcd), .zero_o(zero_bcd)
  );

  dcnt_divider #(.CNT_W(4), .BCD_MODE(1'b0), .SYNC_STAGES(2)) u_bin (
    .clk(clk), .rst(rst), .cnt_clk_i(cnt_clk), .inh_i(inh), .clr_i(clr),
    .load_i(load_bin), .preset_i(preset), .casc_fb_i(cf),
    .count_o(cnt_bin), .zero_o(zero_bin)
  );

  always @(negedge clk) begin
    if (fb_mode && zero_bcd && !zero_prev) zpulses++;
    zero_prev <= zero_bcd;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_load(input logic [3:0] v);
    preset = v; load_r = 1'b1; tick(1);
    load_r = 1'b0; tick(1);
  endtask

  task automatic pulse_clk();
    cnt_clk = 1'b1; tick(4);
    cnt_clk = 1'b0; tick(4);
  endtask

  task automatic t_reset();
    tick(1);
    check("R9", "zero during reset", zero_bcd, 0);
    rst = 1'b0; tick(1);
    check("R9", "count after reset", cnt_bcd, 0);
    check("R6", "zero with count 0 and feedback high", zero_bcd, 1);
  endtask

  task automatic t_load();
    do_load(4'd7);
    check("R2", "loaded value", cnt_bcd, 7);
    preset = 4'd7; load_r = 1'b1;
    pulse_clk();
    check("R2", "edge discarded during load", cnt_bcd, 7);
    load_r = 1'b0; tick(1);
  endtask

  task automatic t_rise_dec();
    cnt_clk = 1'b1; tick(2);
    check("R3", "no update before third edge", cnt_bcd, 7);
    tick(1);
    check("R3", "update on third edge", cnt_bcd, 6);
    tick(2);
    cnt_clk = 1'b0; tick(4);
    check("R5", "falling count clock ignored", cnt_bcd, 6);
  endtask

  task automatic t_inhibit();
    inh = 1'b1; tick(4);
    check("R5", "rising inhibit ignored", cnt_bcd, 6);
    cnt_clk = 1'b1; tick(4);
    check("R5", "rising clock blocked by inhibit", cnt_bcd, 6);
    inh = 1'b0; tick(4);
    check("R4", "falling inhibit with clock high", cnt_bcd, 5);
    cnt_clk = 1'b0; tick(4);
    check("R5", "falling clock after inhibit count", cnt_bcd, 5);
  endtask

  task automatic t_wrap_zero();
    do_load(4'd0);
    check("R6", "zero flag at 0 with feedback", zero_bcd, 1);
    cf = 1'b0; tick(1);
    check("R6", "zero flag masked by feedback low", zero_bcd, 0);
    cf = 1'b1;
    pulse_clk();
    check("R7", "BCD wrap", cnt_bcd, 9);
    check("R7", "binary wrap", cnt_bin, 15);
    check("R6", "zero flag low at nonzero count", zero_bcd, 0);
  endtask

  task automatic t_bcd_high();
    do_load(4'd12);
    check("R8", "BCD preset 12 kept", cnt_bcd, 12);
    pulse_clk();
    check("R8", "BCD 12 decrements to 11", cnt_bcd, 11);
  endtask

  task automatic t_clear();
    preset = 4'd5; load_r = 1'b1; clr = 1'b1; cf = 1'b0;
    cnt_clk = 1'b1; tick(4);
    check("R1", "clear beats load and edges", cnt_bcd, 0);
    check("R1", "zero low during clear with feedback low", zero_bcd, 0);
    clr = 1'b0; load_r = 1'b0; cnt_clk = 1'b0; cf = 1'b1; tick(4);
  endtask

  task automatic t_divide();
    do_load(4'd3);
    zpulses = 0; fb_mode = 1'b1;
    for (int i = 0; i < 9; i++) pulse_clk();
    check("R10", "zero pulses over 9 events with N=3", zpulses, 3);
    check("R10", "count back at preset", cnt_bcd, 3);
    fb_mode = 1'b0; tick(1);
  endtask

  initial begin
    fork
      begin
        tick(3);
        t_reset();
        t_load();
        t_rise_dec();
        t_inhibit();
        t_wrap_zero();
        t_bcd_high();
        t_clear();
        t_divide();
      end
      begin
        tick(20000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule